// File: doc/BRIEF.md
# Serial Test Chain Around a Processor Core (No Update Latch)

This block places one scan cell on every input of a processor core and one on every output, and joins all of the cells into a single serial path from TDI to TDO. A test-access controller outside the block supplies three strobes: capture, shift and run-idle. It also supplies a decoded two-bit test mode and a flag that is high once the chain-select instruction has loaded chain number zero. When the chain is not selected, or the mode is not a test mode, the cells are idle. In that case system inputs reach the core unchanged, and core outputs reach the system unchanged.

In internal test, the input cells drive the core's inputs. A capture strobe samples the core's outputs into the output cells. A run-idle visit produces exactly one core clock pulse. In external test, the output cells drive the pins that face the system. A capture strobe samples the system-side inputs into the input cells.

The cells have no update latch. Every shift therefore changes the driven side at once, on every scan clock. Logic that receives these values must tolerate the toggling.

Top module: `scan_chain_noupd`

## Requirements
- R1: While `rst_n` is low, every cell is cleared, `tdo` is 0 and `core_clk_pulse` is 0.
- R2: The chain is inactive when `mode` is 2'b00 (system), when `mode` is 2'b11 (spare, treated as system), or when `chain_sel` is low. While inactive, `core_in` equals `sys_in` and `sys_out` equals `core_out`. In external test (2'b10), `core_in` also equals `sys_in`.
- R3: While the chain is inactive, `cap_dr` and `shift_dr` have no effect, and every cell keeps its contents.
- R4: The chain has NUM_IN+NUM_OUT bits. Bit 0 is nearest TDO, and output cell k is bit k. Input cell k is bit NUM_OUT+k. On each rising `tck` edge with `shift_dr` high in an active mode, each bit moves one place toward TDO and `tdi` enters the top bit. A full shift after capture therefore returns output cell 0 first.
- R5: `tdo` changes only on the falling edge of `tck`, where it takes the value of chain bit 0.
- R6: In internal test (mode 2'b01), a `cap_dr` edge loads `core_out` into the output cells and leaves the input cells unchanged.
- R7: In internal test, `core_in` equals the input cells and follows them after every shift edge.
- R8: In internal test, each rising edge of `rti` produces one `core_clk_pulse` that is exactly one `tck` cycle wide, however long `rti` stays high. No pulse occurs in any other mode.
- R9: In external test (mode 2'b10), a `cap_dr` edge loads `sys_in` into the input cells and leaves the output cells unchanged.
- R10: In external test, `sys_out` equals the output cells and follows them after every shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; cells shift on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| cap_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| rti | input | 1 | Run-test-idle state strobe |
| mode | input | 2 | 00 system, 01 internal test, 10 external test, 11 spare |
| chain_sel | input | 1 | High when chain zero is the selected chain |
| sys_in | input | NUM_IN | Signals from the system toward the core |
| core_in | output | NUM_IN | Signals presented to the core's inputs |
| core_out | input | NUM_OUT | Signals produced by the core |
| sys_out | output | NUM_OUT | Signals presented to the system |
| core_clk_pulse | output | 1 | Single core clock pulse during internal test |

## Verification
The behaviour hardest to observe from the ports is that the driven side follows every shift edge, because the chain state is visible only one bit at a time through TDO. To reach that state, the stimulus captures a known word, then shifts a full chain length with a distinct pattern. After each rising edge it compares `core_in` (internal test) or `sys_out` (external test) against a bench model of the chain. A scoreboard queue holds the TDO bit expected at each falling edge. Strobes are also applied while the chain is deselected or in the spare mode, and a later shift-out then shows that the cells kept their contents.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        SM_SYSTEM   = 2'b00,
        SM_INTERNAL = 2'b01,
        SM_EXTERNAL = 2'b10,
        SM_SPARE    = 2'b11
    } scan_mode_e;

    typedef struct packed {
        logic int_act;
        logic ext_act;
    } mode_dec_t;
endpackage

// File: rtl/scan_mode_decode.sv
module scan_mode_decode
    import scan_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       chain_sel_i,
    output mode_dec_t  dec_o
);
    scan_mode_e m;

    always_comb begin
        m = scan_mode_e'(mode_i);
        dec_o = '0;
        if (chain_sel_i) begin
            unique case (m)
                SM_INTERNAL: dec_o.int_act = 1'b1;
                SM_EXTERNAL: dec_o.ext_act = 1'b1;
                default:     dec_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/scan_cell_chain.sv
module scan_cell_chain #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tdi_i,
    input  logic               cap_core_i,
    input  logic               cap_sys_i,
    input  logic               shift_i,
    input  logic [NUM_OUT-1:0] core_out_i,
    input  logic [NUM_IN-1:0]  sys_in_i,
    output logic [NUM_IN-1:0]  in_cells_o,
    output logic [NUM_OUT-1:0] out_cells_o,
    output logic               tail_o
);
    localparam int LEN = NUM_IN + NUM_OUT;

    typedef struct packed {
        logic [LEN-1:0] cells;
    } chain_st_t;

    chain_st_t s_d, s_q;
    logic [LEN-1:0] serial_src;

    // serial source for each cell: its upstream neighbour, top cell takes tdi
    for (genvar g = 0; g < LEN; g++) begin : g_src
        if (g == LEN - 1) begin : g_top
            assign serial_src[g] = tdi_i;
        end else begin : g_mid
            assign serial_src[g] = s_q.cells[g+1];
        end
    end

    always_comb begin
        s_d = s_q;
        if (cap_core_i || cap_sys_i) begin
            if (cap_core_i) s_d.cells[NUM_OUT-1:0]   = core_out_i;
            if (cap_sys_i)  s_d.cells[LEN-1:NUM_OUT] = sys_in_i;
        end else if (shift_i) begin
            s_d.cells = serial_src;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign out_cells_o = s_q.cells[NUM_OUT-1:0];
    assign in_cells_o  = s_q.cells[LEN-1:NUM_OUT];
    assign tail_o      = s_q.cells[0];

    p_shift_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !cap_core_i && !cap_sys_i) |=>
            (s_q.cells[LEN-2:0] == $past(s_q.cells[LEN-1:1])) && (s_q.cells[LEN-1] == $past(tdi_i)));

    p_cap_core_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_core_i && !cap_sys_i) |=>
            (out_cells_o == $past(core_out_i)) && $stable(in_cells_o));

    p_cap_sys_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_sys_i && !cap_core_i) |=>
            (in_cells_o == $past(sys_in_i)) && $stable(out_cells_o));
endmodule

// File: rtl/scan_tdo_stage.sv
module scan_tdo_stage (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bit_i,
    output logic tdo_o
);
    typedef struct packed {
        logic tdo;
    } tdo_st_t;

    tdo_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.tdo = bit_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign tdo_o = s_q.tdo;

    // at the rising edge the chain has not yet moved, so tdo must match its tail
    p_tdo_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tdo_o == bit_i);
endmodule

// File: rtl/scan_core_clk.sv
module scan_core_clk (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic int_act_i,
    input  logic rti_i,
    output logic pulse_o
);
    typedef struct packed {
        logic rti_seen;
        logic pulse;
    } clk_st_t;

    clk_st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.pulse    = int_act_i && rti_i && !s_q.rti_seen;
        s_d.rti_seen = int_act_i && rti_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pulse_o = s_q.pulse;

    p_pulse_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> $past(int_act_i && rti_i));
endmodule

// File: rtl/scan_chain_noupd.sv
module scan_chain_noupd
    import scan_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    output logic               tdo,
    input  logic               cap_dr,
    input  logic               shift_dr,
    input  logic               rti,
    input  logic [1:0]         mode,
    input  logic               chain_sel,
    input  logic [NUM_IN-1:0]  sys_in,
    output logic [NUM_IN-1:0]  core_in,
    input  logic [NUM_OUT-1:0] core_out,
    output logic [NUM_OUT-1:0] sys_out,
    output logic               core_clk_pulse
);
    mode_dec_t          dec;
    logic               active;
    logic               cap_core, cap_sys, shift_en;
    logic [NUM_IN-1:0]  in_cells;
    logic [NUM_OUT-1:0] out_cells;
    logic               tail;

    scan_mode_decode u_dec (
        .mode_i      (mode),
        .chain_sel_i (chain_sel),
        .dec_o       (dec)
    );

    always_comb begin
        active   = dec.int_act || dec.ext_act;
        cap_core = dec.int_act && cap_dr;
        cap_sys  = dec.ext_act && cap_dr;
        shift_en = active && shift_dr;
    end

    scan_cell_chain #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chain (
        .clk_i       (tck),
        .rst_ni      (rst_n),
        .tdi_i       (tdi),
        .cap_core_i  (cap_core),
        .cap_sys_i   (cap_sys),
        .shift_i     (shift_en),
        .core_out_i  (core_out),
        .sys_in_i    (sys_in),
        .in_cells_o  (in_cells),
        .out_cells_o (out_cells),
        .tail_o      (tail)
    );

    scan_tdo_stage u_tdo (
        .clk_i  (tck),
        .rst_ni (rst_n),
        .bit_i  (tail),
        .tdo_o  (tdo)
    );

    scan_core_clk u_cclk (
        .clk_i     (tck),
        .rst_ni    (rst_n),
        .int_act_i (dec.int_act),
        .rti_i     (rti),
        .pulse_o   (core_clk_pulse)
    );

    // no update latch: the cells feed the driven side directly
    always_comb begin
        core_in = dec.int_act ? in_cells  : sys_in;
        sys_out = dec.ext_act ? out_cells : core_out;
    end

    p_idle_pass_r2: assert property (@(posedge tck) disable iff (!rst_n)
        !(dec.int_act || dec.ext_act) |-> (core_in == sys_in) && (sys_out == core_out));

    p_idle_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
        !active |=> $stable(in_cells) && $stable(out_cells));

    p_int_drive_r7: assert property (@(posedge tck) disable iff (!rst_n)
        dec.int_act |-> (core_in == in_cells) && (sys_out == core_out));

    p_ext_drive_r10: assert property (@(posedge tck) disable iff (!rst_n)
        dec.ext_act |-> (sys_out == out_cells) && (core_in == sys_in));
endmodule

// File: tb/scan_chain_noupd_tb.sv
module scan_chain_noupd_tb;
    localparam int NI  = 8;
    localparam int NO  = 8;
    localparam int LEN = NI + NO;

    logic          tck = 1'b0;
    logic          rst_n, tdi, tdo, cap_dr, shift_dr, rti, chain_sel, core_clk_pulse;
    logic [1:0]    mode;
    logic [NI-1:0] sys_in, core_in;
    logic [NO-1:0] core_out, sys_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic          exp_q[$];
    string         req_q[$];
    logic [LEN-1:0] model;

    always #2 tck = ~tck;

    scan_chain_noupd #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
        .cap_dr(cap_dr), .shift_dr(shift_dr), .rti(rti),
        .mode(mode), .chain_sel(chain_sel),
        .sys_in(sys_in), .core_in(core_in),
        .core_out(core_out), .sys_out(sys_out),
        .core_clk_pulse(core_clk_pulse)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // monitor: compares tdo after each falling edge against the scoreboard
    always @(negedge tck) begin
        #1;
        if (exp_q.size() > 0) begin
            logic  e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(r, {31'd0, tdo}, {31'd0, e});
        end
    end

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic capture(string req);
        if (mode == 2'b01 && chain_sel) model[NO-1:0]   = core_out;
        if (mode == 2'b10 && chain_sel) model[LEN-1:NO] = sys_in;
        cap_dr = 1'b1;
        step();
        cap_dr = 1'b0;
    endtask

    task automatic shift_all(logic [LEN-1:0] pat, string req);
        for (int i = 0; i < LEN; i++) begin
            logic prev;
            shift_dr = 1'b1;
            tdi      = pat[i];
            prev     = model[0];
            exp_q.push_back(model[0]);
            req_q.push_back(req);
            step();
            model = {pat[i], model[LEN-1:1]};
            // R5: tdo still shows the pre-edge bit until the falling edge
            chk("R5", {31'd0, tdo}, {31'd0, prev});
            if (mode == 2'b01) chk("R7", {24'd0, core_in}, {24'd0, model[LEN-1:NO]});
            if (mode == 2'b10) chk("R10", {24'd0, sys_out}, {24'd0, model[NO-1:0]});
        end
        shift_dr = 1'b0;
    endtask

    task automatic count_pulses(int ncyc, int rti_cycles, output int cnt);
        cnt = 0;
        rti = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge tck);
            #1;
            cnt += int'(core_clk_pulse);
            step();
            if (k == rti_cycles - 1) rti = 1'b0;
        end
        rti = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; tdi = 1'b0; cap_dr = 1'b0; shift_dr = 1'b0; rti = 1'b0;
        mode = 2'b00; chain_sel = 1'b0; sys_in = 8'h3C; core_out = 8'hC3;
        model = '0;
        step(); step();
        // R1 reset state
        chk("R1", {31'd0, tdo}, 32'd0);
        chk("R1", {31'd0, core_clk_pulse}, 32'd0);
        chk("R2", {24'd0, core_in}, 32'h3C);
        chk("R2", {24'd0, sys_out}, 32'hC3);
        rst_n = 1'b1;
        step();

        // R2 spare mode with chain selected behaves as system
        mode = 2'b11; chain_sel = 1'b1; sys_in = 8'h81; core_out = 8'h7E;
        #1;
        chk("R2", {24'd0, core_in}, 32'h81);
        chk("R2", {24'd0, sys_out}, 32'h7E);

        // R3 strobes while inactive: deselected internal test, then spare mode
        mode = 2'b01; chain_sel = 1'b0; core_out = 8'hFF; sys_in = 8'h55;
        cap_dr = 1'b1; step(); cap_dr = 1'b0;
        tdi = 1'b1; shift_dr = 1'b1; step(); step(); step(); shift_dr = 1'b0;
        chk("R2", {24'd0, core_in}, 32'h55);
        mode = 2'b11; chain_sel = 1'b1;
        cap_dr = 1'b1; step(); cap_dr = 1'b0;
        shift_dr = 1'b1; step(); step(); shift_dr = 1'b0;
        mode = 2'b00;
        cap_dr = 1'b1; shift_dr = 1'b1; step(); cap_dr = 1'b0; shift_dr = 1'b0;
        // chain must still hold zeros: shift it out in internal test
        mode = 2'b01; chain_sel = 1'b1;
        shift_all(16'h0000, "R3");

        // R6/R4/R7: capture core outputs then full shift
        core_out = 8'hA5;
        capture("R6");
        shift_all(16'h96C3, "R4");
        chk("R7", {24'd0, core_in}, 32'h96);
        chk("R7", {24'd0, sys_out}, 32'hA5);

        // R6 input cells untouched by an internal capture, seen via shift-out
        core_out = 8'h0F;
        capture("R6");
        shift_all(16'h4B21, "R6");

        // R8 single pulse per run-idle visit, however long
        count_pulses(5, 3, n);
        chk("R8", n, 1);
        count_pulses(3, 1, n);
        chk("R8", n, 1);

        // R9/R10 external test
        mode = 2'b10; sys_in = 8'h5A; core_out = 8'h33;
        #1;
        chk("R10", {24'd0, sys_out}, {24'd0, model[NO-1:0]});
        chk("R2", {24'd0, core_in}, 32'h5A);
        capture("R9");
        shift_all(16'h1E2D, "R9");
        chk("R10", {24'd0, sys_out}, 32'h2D);
        chk("R2", {24'd0, core_in}, 32'h5A);

        // R8 no pulse in external test
        count_pulses(4, 2, n);
        chk("R8", n, 0);

        // R1 reset in mid-test clears chain and tdo
        rst_n = 1'b0; model = '0;
        #1;
        chk("R1", {31'd0, tdo}, 32'd0);
        chk("R1", {24'd0, sys_out}, 32'h00);
        step();
        rst_n = 1'b1;
        step();
        shift_all(16'hFFFF, "R1");

        step(); step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule